// File: doc/BRIEF.md
# Circular Stack Cache with Burst Spill and Fill

This block keeps the topmost words of a processor's data stack in a small on-chip register array addressed as a ring. A push writes the next slot and a pop releases the top slot, and both move only a pointer. The top word is always readable combinationally, so the CPU's push, pop and top-of-stack accesses each complete in one cycle.

A transfer controller watches how many words the ring holds. When the ring is nearly full, it copies its oldest words to a backing memory as one aligned burst. When the ring is nearly empty and words are parked in backing memory, it reads the most recently parked burst back in below the ring's current bottom. These transfers start as soon as a threshold is crossed and the memory port has no burst in flight. They run alongside CPU traffic, and the CPU is held only when an operation needs a slot or a word that a pending transfer must provide first.

Top module: `stk_cache`

## Requirements
- R1: An accepted push makes its data the top word (`cpu_top`) from the next cycle. An accepted pop removes the top word, so the words come back in last-in, first-out order across any number of spills and fills.
- R2: A push and a pop accepted in the same cycle overwrite the top word with the pushed data and leave the stack depth unchanged.
- R3: When the ring holds 12 or more words and no burst is in flight, the block issues a write request (`mem_we`=1) at the backing pointer. The backing pointer is the number of words already parked, starting at 0. The burst carries the 4 oldest cached words, oldest at the lowest address, and the pointer then rises by 4.
- R4: Every request address is a multiple of 4 words, the burst length.
- R5: When the ring holds 4 or fewer words and the backing pointer is non-zero, the block issues a read request (`mem_we`=0) at the backing pointer minus 4. The 4 returned words go below the current bottom, the first returned word lowest, and the pointer then falls by 4.
- R6: Only one burst is in flight at a time. A request stays asserted with a stable address and direction until `mem_gnt` is seen high at a clock edge.
- R7: A push without a pop while the ring holds 16 words raises `cpu_stall` until a spill frees room. No word is lost.
- R8: A pop while the ring is empty and the backing pointer is non-zero raises `cpu_stall` until the fill returns words.
- R9: A pop when both the ring and the backing store are empty sets `cpu_underflow`, which stays set until reset, and changes no stack state. Later pushes and pops behave normally.
- R10: After reset the stack is empty, `cpu_stall`, `cpu_underflow`, `mem_req` and `mem_wvalid` are low, and the backing pointer is 0.
- R11: Write data beats (`mem_wvalid`) appear on the 4 cycles right after the granted write request, one word per cycle. Read beats are taken whenever `mem_rvalid` is high during a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_push | input | 1 | Push request |
| cpu_pop | input | 1 | Pop request |
| cpu_wdata | input | DW | Data to push |
| cpu_top | output | DW | Current top word |
| cpu_stall | output | 1 | Requested operation is held this cycle |
| cpu_underflow | output | 1 | Sticky underflow flag |
| mem_req | output | 1 | Burst request |
| mem_we | output | 1 | Request direction: 1 write (spill), 0 read (fill) |
| mem_addr | output | BAW | Burst base word address |
| mem_gnt | input | 1 | Request accepted at this edge |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wdata | output | DW | Write beat data |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DW | Read beat data |

## Verification
Random operation streams alternate between phases biased toward pushes and phases biased toward pops. This drives the depth through many spill and fill crossings, while the memory grants late at random and returns read beats with random gaps. Any misplaced slot or wrong burst order then shows up as a wrong popped value or a wrong address. Mixed push-and-pop cycles separate a true top replacement from a push followed by a pop. Directed runs with grants withheld show that the full-ring push and the empty-ring pop are held exactly until memory responds. A final drain and an extra pop show that underflow is flagged, kept, and leaves the stack usable.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int unsigned STK_DEPTH_DEF = 16;
    localparam int unsigned STK_HI_DEF    = 12;
    localparam int unsigned STK_LO_DEF    = 4;
    localparam int unsigned STK_BURST_DEF = 4;

    typedef enum logic [2:0] {
        XF_IDLE,
        XF_SPILL_REQ,
        XF_SPILL_DATA,
        XF_FILL_REQ,
        XF_FILL_DATA
    } xfer_state_e;

    typedef struct packed {
        logic spill_busy;
        logic fill_busy;
        logic spill_done;
        logic fill_done;
    } xfer_stat_t;

    typedef struct packed {
        logic push;
        logic pop;
    } cpu_op_t;

endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PAW  = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           a_we,
    input  logic [PAW-1:0] a_addr,
    input  logic [DW-1:0]  a_data,
    input  logic           b_we,
    input  logic [PAW-1:0] b_addr,
    input  logic [DW-1:0]  b_data,
    input  logic [PAW-1:0] top_addr,
    output logic [DW-1:0]  top_data,
    input  logic [PAW-1:0] sp_addr,
    output logic [DW-1:0]  sp_data
);

    logic [DW-1:0] slots [DEPTH];

    // CPU port wins by construction; the two ports never target one slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (a_we && a_addr == PAW'(i)) begin
                slots[i] <= a_data;
            end else if (b_we && b_addr == PAW'(i)) begin
                slots[i] <= b_data;
            end
        end
    end

    assign top_data = slots[top_addr];
    assign sp_data  = slots[sp_addr];

    AST_NO_SLOT_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(a_we && b_we && a_addr == b_addr)); // R5

endmodule

// File: rtl/stk_xfer.sv
module stk_xfer
    import stk_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = STK_DEPTH_DEF,
    parameter int unsigned HI    = STK_HI_DEF,
    parameter int unsigned LO    = STK_LO_DEF,
    parameter int unsigned BURST = STK_BURST_DEF,
    parameter int unsigned BAW   = 10,
    localparam int unsigned PAW  = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned BW   = $clog2(BURST)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  occ,
    input  logic [BAW-1:0] bsp,
    input  logic [PAW-1:0] bottom,
    input  logic [DW-1:0]  sp_data,
    output logic [PAW-1:0] sp_addr,
    output logic           fill_we,
    output logic [PAW-1:0] fill_addr,
    output logic [DW-1:0]  fill_data,
    output xfer_stat_t     stat,
    output logic           mem_req,
    output logic           mem_we,
    output logic [BAW-1:0] mem_addr,
    input  logic           mem_gnt,
    output logic           mem_wvalid,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata
);

    localparam logic [CW-1:0]  HI_C    = CW'(HI);
    localparam logic [CW-1:0]  LO_C    = CW'(LO);
    localparam logic [PAW-1:0] BURST_P = PAW'(BURST);
    localparam logic [BAW-1:0] BURST_B = BAW'(BURST);
    localparam logic [BW-1:0]  LAST_B  = BW'(BURST - 1);

    xfer_state_e    state;
    logic [PAW-1:0] base;
    logic [BW-1:0]  beat;
    logic [PAW-1:0] slot;

    assign slot = base + PAW'(beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= XF_IDLE;
            base  <= '0;
            beat  <= '0;
        end else begin
            unique case (state)
                XF_IDLE: begin
                    beat <= '0;
                    if (occ >= HI_C) begin
                        state <= XF_SPILL_REQ;
                        base  <= bottom;
                    end else if (occ <= LO_C && bsp != '0) begin
                        state <= XF_FILL_REQ;
                        base  <= bottom - BURST_P;
                    end
                end
                XF_SPILL_REQ: begin
                    if (mem_gnt) state <= XF_SPILL_DATA;
                end
                XF_SPILL_DATA: begin
                    beat <= beat + BW'(1);
                    if (beat == LAST_B) state <= XF_IDLE;
                end
                XF_FILL_REQ: begin
                    if (mem_gnt) state <= XF_FILL_DATA;
                end
                XF_FILL_DATA: begin
                    if (mem_rvalid) begin
                        beat <= beat + BW'(1);
                        if (beat == LAST_B) state <= XF_IDLE;
                    end
                end
                default: state <= XF_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = (state == XF_SPILL_REQ) || (state == XF_FILL_REQ);
        mem_we   = (state == XF_SPILL_REQ);
        mem_addr = (state == XF_FILL_REQ) ? bsp - BURST_B : bsp;
    end

    assign sp_addr    = slot;
    assign mem_wvalid = (state == XF_SPILL_DATA);
    assign mem_wdata  = sp_data;
    assign fill_we    = (state == XF_FILL_DATA) && mem_rvalid;
    assign fill_addr  = slot;
    assign fill_data  = mem_rdata;

    always_comb begin
        stat.spill_busy = (state == XF_SPILL_REQ) || (state == XF_SPILL_DATA);
        stat.fill_busy  = (state == XF_FILL_REQ) || (state == XF_FILL_DATA);
        stat.spill_done = (state == XF_SPILL_DATA) && (beat == LAST_B);
        stat.fill_done  = (state == XF_FILL_DATA) && mem_rvalid && (beat == LAST_B);
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R6
    AST_BEAT_NOT_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_wvalid |-> !mem_req); // R11
    AST_FILL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (bsp >= BURST_B)); // R5

endmodule

// File: rtl/stk_cache.sv
module stk_cache
    import stk_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = STK_DEPTH_DEF,
    parameter int unsigned HI    = STK_HI_DEF,
    parameter int unsigned LO    = STK_LO_DEF,
    parameter int unsigned BURST = STK_BURST_DEF,
    parameter int unsigned BAW   = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cpu_push,
    input  logic           cpu_pop,
    input  logic [DW-1:0]  cpu_wdata,
    output logic [DW-1:0]  cpu_top,
    output logic           cpu_stall,
    output logic           cpu_underflow,
    output logic           mem_req,
    output logic           mem_we,
    output logic [BAW-1:0] mem_addr,
    input  logic           mem_gnt,
    output logic           mem_wvalid,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata
);

    localparam int unsigned PAW = $clog2(DEPTH);
    localparam int unsigned CW  = $clog2(DEPTH + 1);
    localparam logic [CW-1:0]  DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0]  BURST_C = CW'(BURST);
    localparam logic [CW-1:0]  ROOM_C  = CW'(DEPTH - BURST);
    localparam logic [BAW-1:0] BURST_B = BAW'(BURST);

    cpu_op_t        op;
    xfer_stat_t     stat;
    logic [PAW-1:0] wp;
    logic [CW-1:0]  count;
    logic [BAW-1:0] bsp;
    logic           uflow;

    logic [PAW-1:0] bottom, top_slot, wr_slot;
    logic           empty, bs_empty, pop_wait, push_wait, uf_hit;
    logic           go_push, go_pop;
    logic [CW-1:0]  count_n;
    logic [BAW-1:0] bsp_n;
    logic [PAW-1:0] wp_n;

    logic           sp_fill_we;
    logic [PAW-1:0] sp_fill_addr, sp_rd_addr;
    logic [DW-1:0]  sp_fill_data, sp_rd_data;

    assign op       = '{push: cpu_push, pop: cpu_pop};
    assign bottom   = wp - PAW'(count);
    assign top_slot = wp - PAW'(1);
    assign empty    = (count == '0);
    assign bs_empty = (bsp == '0);

    // Hold conditions: slots being copied out, or words still parked.
    assign pop_wait  = (stat.spill_busy && count <= BURST_C) || (empty && !bs_empty);
    assign push_wait = (count == DEPTH_C) || (stat.fill_busy && count >= ROOM_C);
    assign uf_hit    = op.pop && empty && bs_empty;
    assign cpu_stall = op.pop ? pop_wait : (op.push && push_wait);

    assign go_push = op.push && !cpu_stall && !uf_hit;
    assign go_pop  = op.pop && !cpu_stall && !uf_hit;
    assign wr_slot = go_pop ? top_slot : wp;

    always_comb begin
        wp_n    = wp;
        count_n = count;
        if (go_push && !go_pop) begin
            wp_n    = wp + PAW'(1);
            count_n = count + CW'(1);
        end else if (go_pop && !go_push) begin
            wp_n    = wp - PAW'(1);
            count_n = count - CW'(1);
        end
        if (stat.spill_done) count_n = count_n - BURST_C;
        if (stat.fill_done)  count_n = count_n + BURST_C;
    end

    always_comb begin
        bsp_n = bsp;
        if (stat.spill_done) bsp_n = bsp + BURST_B;
        else if (stat.fill_done) bsp_n = bsp - BURST_B;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            count <= '0;
            bsp   <= '0;
            uflow <= 1'b0;
        end else begin
            wp    <= wp_n;
            count <= count_n;
            bsp   <= bsp_n;
            if (uf_hit) uflow <= 1'b1;
        end
    end

    assign cpu_underflow = uflow;

    stk_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .clk      (clk),
        .rst      (rst),
        .a_we     (go_push),
        .a_addr   (wr_slot),
        .a_data   (cpu_wdata),
        .b_we     (sp_fill_we),
        .b_addr   (sp_fill_addr),
        .b_data   (sp_fill_data),
        .top_addr (top_slot),
        .top_data (cpu_top),
        .sp_addr  (sp_rd_addr),
        .sp_data  (sp_rd_data)
    );

    stk_xfer #(
        .DW(DW), .DEPTH(DEPTH), .HI(HI), .LO(LO), .BURST(BURST), .BAW(BAW)
    ) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .occ        (count),
        .bsp        (bsp),
        .bottom     (bottom),
        .sp_data    (sp_rd_data),
        .sp_addr    (sp_rd_addr),
        .fill_we    (sp_fill_we),
        .fill_addr  (sp_fill_addr),
        .fill_data  (sp_fill_data),
        .stat       (stat),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_wvalid (mem_wvalid),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata)
    );

    AST_COUNT_MAX: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_C); // R7
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr % BURST_B == '0)); // R4
    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        cpu_underflow |=> cpu_underflow); // R9
    AST_UFLOW_NOCHANGE: assert property (@(posedge clk) disable iff (rst)
        (cpu_pop && count == '0 && bsp == '0) |=> (count == '0 && bsp == '0)); // R9

endmodule

// File: tb/stk_cache_bench.sv
`timescale 1ns/1ps
module stk_cache_bench;

    localparam int DW  = 16;
    localparam int BAW = 10;

    logic           clk = 1'b0;
    logic           rst;
    logic           cpu_push, cpu_pop;
    logic [DW-1:0]  cpu_wdata, cpu_top;
    logic           cpu_stall, cpu_underflow;
    logic           mem_req, mem_we, mem_gnt, mem_wvalid, mem_rvalid;
    logic [BAW-1:0] mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    stk_cache u_stk_cache (
        .clk(clk), .rst(rst),
        .cpu_push(cpu_push), .cpu_pop(cpu_pop), .cpu_wdata(cpu_wdata),
        .cpu_top(cpu_top), .cpu_stall(cpu_stall), .cpu_underflow(cpu_underflow),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [DW-1:0] model [0:1023];
    int            depth = 0;
    logic [DW-1:0] bmem [0:1023];
    int            bs_words = 0;
    bit            gnt_en = 1'b1;
    int            wexp = 0, waddr = 0, rleft = 0, raddr = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_spill_addr(input int parked);
        return parked;
    endfunction

    function automatic int exp_fill_addr(input int parked);
        return parked - 4;
    endfunction

    // Backing memory model with random grant and read-beat gaps.
    always @(posedge clk) begin
        if (rst) begin
            mem_gnt    <= 1'b0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            wexp = 0; rleft = 0;
        end else begin
            automatic bit busy_before = (wexp > 0) || (rleft > 0);
            mem_rvalid <= 1'b0;
            if (wexp > 0) begin
                check(mem_wvalid == 1'b1, "R11 write beat", int'(mem_wvalid), 1);
                check(mem_wdata == model[waddr], "R3 spilled word", int'(mem_wdata), int'(model[waddr]));
                bmem[waddr] = mem_wdata;
                waddr++;
                wexp--;
                if (wexp == 0) bs_words += 4;
            end else if (mem_wvalid) begin
                check(1'b0, "R11 stray write beat", 1, 0);
            end
            if (rleft > 0 && ($urandom % 3 != 0)) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= bmem[raddr];
                raddr++;
                rleft--;
                if (rleft == 0) bs_words -= 4;
            end
            if (mem_req && mem_gnt) begin
                check(!busy_before, "R6 single burst", int'(busy_before), 0);
                check(int'(mem_addr) % 4 == 0, "R4 alignment", int'(mem_addr), 0);
                if (mem_we) begin
                    check(int'(mem_addr) == exp_spill_addr(bs_words), "R3 spill address",
                          int'(mem_addr), exp_spill_addr(bs_words));
                    wexp = 4; waddr = int'(mem_addr);
                end else begin
                    check(int'(mem_addr) == exp_fill_addr(bs_words), "R5 fill address",
                          int'(mem_addr), exp_fill_addr(bs_words));
                    rleft = 4; raddr = int'(mem_addr);
                end
            end
            mem_gnt <= gnt_en && ($urandom % 4 != 0);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // Caller is just after a rising edge; returns just after the edge that took the op.
    task automatic op(input bit pu, input bit po, input logic [DW-1:0] d);
        cpu_push = pu; cpu_pop = po; cpu_wdata = d;
        @(negedge clk);
        while (cpu_stall) @(negedge clk);
        if (po && depth > 0)
            check(cpu_top == model[depth-1], "R1 pop value", int'(cpu_top), int'(model[depth-1]));
        @(posedge clk); #1;
        cpu_push = 1'b0; cpu_pop = 1'b0;
        if (po && depth == 0) begin
            // underflow: no state change expected
        end else if (pu && po) begin
            model[depth-1] = d;
            check(cpu_top == d, "R2 replaced top", int'(cpu_top), int'(d));
        end else if (pu) begin
            model[depth] = d;
            depth++;
            check(cpu_top == d, "R1 pushed top", int'(cpu_top), int'(d));
        end else if (po) begin
            depth--;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int seed_val;
        int c;
        seed_val = $urandom(32'd51829);
        rst = 1'b1; cpu_push = 1'b0; cpu_pop = 1'b0; cpu_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(cpu_stall == 1'b0, "R10 stall low", int'(cpu_stall), 0);
        check(cpu_underflow == 1'b0, "R10 underflow low", int'(cpu_underflow), 0);
        check(mem_req == 1'b0, "R10 no request", int'(mem_req), 0);
        check(mem_wvalid == 1'b0, "R10 no write beat", int'(mem_wvalid), 0);
        @(posedge clk); #1;

        // R7: full ring holds a push until the spill is granted.
        gnt_en = 1'b0;
        for (int i = 0; i < 16; i++) op(1'b1, 1'b0, DW'(16'h1000 + i));
        cpu_push = 1'b1; cpu_wdata = 16'h10ff;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(cpu_stall == 1'b1, "R7 push held when full", int'(cpu_stall), 1);
        end
        @(posedge clk); #1;
        gnt_en = 1'b1;
        op(1'b1, 1'b0, 16'h10ff);

        // R8: empty ring with parked words holds a pop until the fill returns.
        idle(60);
        c = depth - bs_words;
        if (c > 4 && c < 12 && bs_words > 0) begin
            gnt_en = 1'b0;
            for (int i = 0; i < c; i++) op(1'b0, 1'b1, '0);
            cpu_pop = 1'b1;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(cpu_stall == 1'b1, "R8 pop held while filling", int'(cpu_stall), 1);
            end
            @(posedge clk); #1;
            gnt_en = 1'b1;
            op(1'b0, 1'b1, '0);
        end else begin
            check(1'b0, "R8 setup depth", c, 8);
        end

        // R2: simultaneous push and pop replaces the top.
        op(1'b1, 1'b0, 16'haaaa);
        op(1'b1, 1'b0, 16'hbbbb);
        op(1'b1, 1'b1, 16'hcccc);
        op(1'b0, 1'b1, '0);
        check(cpu_top == 16'haaaa, "R2 depth kept", int'(cpu_top), 16'haaaa);

        // Random phases swinging depth across spill and fill thresholds.
        for (int i = 0; i < 6000; i++) begin
            int r;
            int pushp;
            pushp = ((i / 250) % 2 == 0) ? 62 : 30;
            r = int'($urandom % 100);
            if (r >= 92) idle(1 + int'($urandom % 4));
            else if (depth == 0 || (r < pushp && depth < 900)) op(1'b1, 1'b0, DW'($urandom));
            else if (r < pushp + 12) op(1'b1, 1'b1, DW'($urandom));
            else op(1'b0, 1'b1, '0);
        end

        // Drain everything: checks LIFO order through fills (R5, R1).
        while (depth > 0) op(1'b0, 1'b1, '0);
        idle(20);
        check(bs_words == 0, "R5 backing drained", bs_words, 0);
        check(cpu_underflow == 1'b0, "R9 no early underflow", int'(cpu_underflow), 0);

        // R9: pop on a totally empty stack.
        op(1'b0, 1'b1, '0);
        check(cpu_underflow == 1'b1, "R9 underflow set", int'(cpu_underflow), 1);
        op(1'b1, 1'b0, 16'h5a5a);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(mem_req == 1'b0, "R9 no transfer after underflow", int'(mem_req), 0);
        end
        @(posedge clk); #1;
        check(cpu_underflow == 1'b1, "R9 underflow sticky", int'(cpu_underflow), 1);
        op(1'b0, 1'b1, '0);
        idle(4);

        finish_run();
    end

endmodule